// File: doc/BRIEF.md
# Program Memory Bank Mapper

This block turns 16-bit code-space addresses from a CPU into 17-bit physical flash addresses spread over four 32 KB banks. The lower half of the code space (address bit 15 clear) is a common window that always lands in bank 0. The upper half is a paged window. Two separate paths translate addresses in it, each picking its bank from its own 2-bit field in one special-function bank-select register. Instruction fetches use the fetch field. Constant reads and flash data moves use the data field.

The register sits at special-function address 0xB1 and can be reached from every register page, so the block has no page input. Software may change the data field from anywhere. The fetch field changes only when the instruction doing the write was itself fetched from bank 0. This stops code running in a paged bank from switching its own bank out from under itself. Accesses flagged as scratchpad ignore the data field. Both paths are combinational from the registered fields.

Top module: `code_bank_mapper`

## Requirements
- R1: After reset the register reads 0x11, so both the fetch field and the data field select bank 1.
- R2: A read at address 0xB1 returns the data field in bits 5:4 and the fetch field in bits 1:0. Bits 7:6 and 3:2 read 0, and writes to them have no effect.
- R3: On both paths, a code address with bit 15 clear maps to physical address {2'b00, addr[14:0]}, whatever either field holds.
- R4: A fetch address with bit 15 set maps to {fetch field, addr[14:0]}. The field codes 00, 01, 10 and 11 select banks 0 to 3.
- R5: A non-scratchpad data address with bit 15 set maps to {data field, addr[14:0]}, using the same bank codes.
- R6: When the scratchpad flag is high, the data path ignores the data field and outputs {2'b00, addr[14:0]}.
- R7: A write to 0xB1 updates the fetch field only when the writing instruction's PC is in bank 0 space. That means PC bit 15 is clear, or PC bit 15 is set while the fetch field is 00. Otherwise the fetch field keeps its value.
- R8: A write to 0xB1 always updates the data field from write-data bits 5:4, even when the fetch part of the same write is blocked.
- R9: A write takes effect at the clock edge that ends its cycle. During the write cycle both paths still use the old fields, and from the next cycle on they use the new ones.
- R10: Writes to any address other than 0xB1 leave the register unchanged, and reads at such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data (0 when the address does not match) |
| exec_pc | input | 16 | PC of the instruction currently executing |
| fetch_addr | input | 16 | Instruction fetch code address |
| fetch_phys | output | 17 | Physical fetch address |
| const_addr | input | 16 | Constant or flash data-move code address |
| const_scratch | input | 1 | Access targets the scratchpad area |
| const_phys | output | 17 | Physical data address |

## Verification
The hardest case to reach is an allowed fetch-field write made from a PC in the upper half. It needs the fetch field to be 00 first, and only a write made from the lower half can put it there. The stimulus therefore clears the register from a lower-half PC, then writes again from PC 0xC000 and checks that the new fetch bank was taken. It then writes from an upper-half PC while a non-zero bank is selected, and checks that only the data field changed.

// File: rtl/code_bank_mapper.sv
module code_bank_mapper #(
  parameter int          AW       = 16,
  parameter int          BW       = 2,
  parameter logic [7:0]  SFR_ADDR = 8'hB1,
  parameter logic [7:0]  RST_VAL  = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic [AW-1:0]     exec_pc,
  input  logic [AW-1:0]     fetch_addr,
  output logic [AW+BW-2:0]  fetch_phys,
  input  logic [AW-1:0]     const_addr,
  input  logic              const_scratch,
  output logic [AW+BW-2:0]  const_phys
);
  localparam int OW = AW - 1;

  logic [BW-1:0] if_bank, co_bank;
  logic          reg_hit, wr_hit, pc_common;

  assign reg_hit   = (sfr_addr == SFR_ADDR);
  assign wr_hit    = sfr_wr && reg_hit;
  assign pc_common = !exec_pc[AW-1] || (if_bank == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_bank <= RST_VAL[BW-1:0];
      co_bank <= RST_VAL[4+BW-1:4];
    end else if (wr_hit) begin
      co_bank <= sfr_wdata[4+BW-1:4];
      if (pc_common) if_bank <= sfr_wdata[BW-1:0];
    end
  end

  assign sfr_rdata = reg_hit ? {2'b00, co_bank, 2'b00, if_bank} : 8'h00;

  assign fetch_phys = {(fetch_addr[AW-1] ? if_bank : {BW{1'b0}}), fetch_addr[OW-1:0]};
  assign const_phys = {((const_addr[AW-1] && !const_scratch) ? co_bank : {BW{1'b0}}),
                       const_addr[OW-1:0]};
endmodule

module code_bank_mapper_chk #(
  parameter int AW = 16,
  parameter int BW = 2,
  parameter logic [7:0] SFR_ADDR = 8'hB1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        sfr_addr,
  input logic              sfr_wr,
  input logic [7:0]        sfr_wdata,
  input logic [7:0]        sfr_rdata,
  input logic [AW-1:0]     exec_pc,
  input logic [AW-1:0]     fetch_addr,
  input logic [AW+BW-2:0]  fetch_phys,
  input logic [AW-1:0]     const_addr,
  input logic              const_scratch,
  input logic [AW+BW-2:0]  const_phys,
  input logic [BW-1:0]     if_bank,
  input logic [BW-1:0]     co_bank
);
  logic hit;
  assign hit = sfr_wr && (sfr_addr == SFR_ADDR);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata[7:6] == 2'b00 && sfr_rdata[3:2] == 2'b00); // R2
  AST_LOW_FETCH_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_addr[AW-1] |-> fetch_phys == {1'b0, fetch_addr}); // R3
  AST_LOW_CONST_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    !const_addr[AW-1] |-> const_phys == {1'b0, const_addr}); // R3
  AST_SCRATCH_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    const_scratch |-> const_phys[AW+BW-2:AW-1] == '0); // R6
  AST_FETCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && exec_pc[AW-1] && if_bank != '0) |=> $stable(if_bank)); // R7
  AST_CONST_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> co_bank == $past(sfr_wdata[4+BW-1:4])); // R8
  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(if_bank) && $stable(co_bank)); // R10
endmodule

bind code_bank_mapper code_bank_mapper_chk #(.AW(AW), .BW(BW), .SFR_ADDR(SFR_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
  .sfr_rdata(sfr_rdata), .exec_pc(exec_pc), .fetch_addr(fetch_addr), .fetch_phys(fetch_phys),
  .const_addr(const_addr), .const_scratch(const_scratch), .const_phys(const_phys),
  .if_bank(if_bank), .co_bank(co_bank)
);

// File: tb/tb_code_bank_mapper.sv
module tb_code_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic [15:0] exec_pc = 16'h0000;
  logic [15:0] fetch_addr = 16'h0000;
  logic [16:0] fetch_phys;
  logic [15:0] const_addr = 16'h0000;
  logic        const_scratch = 1'b0;
  logic [16:0] const_phys;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  code_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .exec_pc(exec_pc), .fetch_addr(fetch_addr), .fetch_phys(fetch_phys),
    .const_addr(const_addr), .const_scratch(const_scratch), .const_phys(const_phys)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input logic [15:0] pc);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; exec_pc = pc; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = 8'hB1;
    #1;
  endtask

  task automatic read_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a; #1;
    chk(req, sfr_rdata, exp);
  endtask

  task automatic fetch_at(input string req, input logic [15:0] a, input logic [16:0] exp);
    fetch_addr = a; #1;
    chk(req, fetch_phys, exp);
  endtask

  task automatic const_at(input string req, input logic [15:0] a, input logic s, input logic [16:0] exp);
    const_addr = a; const_scratch = s; #1;
    chk(req, const_phys, exp);
  endtask

  task automatic t_reset;
    read_reg("R1 reset value", 8'hB1, 8'h11);
    fetch_at("R1 fetch bank 1", 16'h9234, 17'h09234);
    const_at("R1 data bank 1", 16'hC000, 1'b0, 17'h0C000);
  endtask

  task automatic t_lower;
    fetch_at("R3 fetch lower", 16'h7FFF, 17'h07FFF);
    const_at("R3 data lower", 16'h0000, 1'b0, 17'h00000);
  endtask

  task automatic t_write_common;
    reg_write(8'hB1, 8'hFF, 16'h0100);
    read_reg("R2 reserved bits read 0", 8'hB1, 8'h33);
    fetch_at("R4 fetch bank 3", 16'hFFFF, 17'h1FFFF);
    const_at("R5 data bank 3", 16'h8001, 1'b0, 17'h18001);
    fetch_at("R3 fetch lower with bank 3", 16'h1234, 17'h01234);
  endtask

  task automatic t_blocked;
    reg_write(8'hB1, 8'h12, 16'h8000);
    read_reg("R7 fetch field kept / R8 data field taken", 8'hB1, 8'h13);
    fetch_at("R7 fetch still bank 3", 16'h8000, 17'h18000);
    const_at("R8 data now bank 1", 16'hA000, 1'b0, 17'h0A000);
  endtask

  task automatic t_upper_from_bank0;
    reg_write(8'hB1, 8'h00, 16'h0200);
    read_reg("R7 cleared from lower half", 8'hB1, 8'h00);
    fetch_at("R4 fetch bank 0", 16'h8000, 17'h00000);
    reg_write(8'hB1, 8'h22, 16'hC000);
    read_reg("R7 write from upper bank 0 taken", 8'hB1, 8'h22);
    fetch_at("R4 fetch bank 2", 16'h8000, 17'h10000);
    const_at("R5 data bank 2", 16'hFFFE, 1'b0, 17'h17FFE);
  endtask

  task automatic t_scratch;
    const_at("R6 scratch upper", 16'h8100, 1'b1, 17'h00100);
    const_at("R6 scratch lower", 16'h0050, 1'b1, 17'h00050);
    const_scratch = 1'b0;
  endtask

  task automatic t_other_addr;
    reg_write(8'hB0, 8'h00, 16'h0000);
    read_reg("R10 other address write ignored", 8'hB1, 8'h22);
    read_reg("R10 other address reads 0", 8'hB0, 8'h00);
    sfr_addr = 8'hB1;
  endtask

  task automatic t_timing;
    @(negedge clk);
    fetch_addr = 16'h8000; const_addr = 16'h8000;
    sfr_addr = 8'hB1; sfr_wdata = 8'h33; exec_pc = 16'h0000; sfr_wr = 1'b1;
    #1;
    chk("R9 fetch old bank during write", fetch_phys, 17'h10000);
    chk("R9 data old bank during write", const_phys, 17'h10000);
    @(negedge clk);
    sfr_wr = 1'b0;
    #1;
    chk("R9 fetch new bank next cycle", fetch_phys, 17'h18000);
    chk("R9 data new bank next cycle", const_phys, 17'h18000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    sfr_addr = 8'hB1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_lower();
    t_write_common();
    t_blocked();
    t_upper_from_bank0();
    t_scratch();
    t_other_addr();
    t_timing();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule